// File: doc/BRIEF.md
# Soft-Start Reference Ramp Sequencer

This block sequences the start-up of a multiphase buck regulator. After the chip is enabled it waits a fixed number of switching cycles. It then raises a digital reference, one 12.5 mV step at a time, until the reference equals the programmed target, and it signals completion. All timing counts switching cycles, which arrive as a one-cycle `tick` strobe that qualifies the faster system clock.

The sequencer keeps the output drivers off while the feedback is still above the ramping reference, so a pre-charged output is not pulled down. It releases them once the reference passes the feedback, or at the end of the ramp at the latest. It also watches the voltage-identification code for the reserved no-load values. On such a code it waits briefly, then stops PWM and selects the shutdown overvoltage threshold. Any other code restarts the whole sequence. An overvoltage fault overrides all of this and holds until chip-enable is removed.

Top module: `softstart_seq`

## Requirements
- R1: While `en` is low, one clock after any edge `ref_out`=0 and `drv_en`, `pwm_en`, `ovp_sel` and `ss_done` are all 0; the same holds during reset.
- R2: After `en` rises (with a normal code), `pwm_en` is 1 from the next clock. `ref_out` stays 0 for 16 ticks of delay, counted from the clock after enable.
- R3: After the delay, `ref_out` rises by exactly 1 every 16 ticks and stops exactly at `target`. With one tick per clock, `ref_out`=k first appears 17+16k clocks after enable.
- R4: Clocks without `tick` do not advance any counter. With a tick on every other clock, starting with the first clock after enable, `ref_out` becomes 1 at clock 65 after enable.
- R5: The no-load codes depend on `vid_mode`. With `vid_mode`=0 the full 6 bits are decoded and only 111111 and 111110 are no-load. With `vid_mode`=1 or 2, only `vid[4:0]`=11111 is no-load and `vid[5]` is ignored. Other codes change nothing.
- R6: A no-load code while running clears `ss_done` on the next clock. `pwm_en` stays 1 for two ticks. At the third clock (one tick per clock) `pwm_en` drops to 0 and `ovp_sel` goes to 1 (shutdown level).
- R7: A normal code after a no-load shutdown sets `ovp_sel`=0 and `pwm_en`=1 on the next clock. It repeats the full delay and ramp, so `ref_out`=1 first appears at clock 33.
- R8: An asserted `ov_latched` forces `pwm_en`, `drv_en` and `ss_done` to 0 and `ref_out` to 0 on the next clock. This state persists through any `vid` changes and after `ov_latched` drops, until `en` is taken low.
- R9: While `fb_above`=1 during delay or ramp, `drv_en` stays 0. The first clock that samples `fb_above`=0 sets `drv_en`=1 from the next clock onward.
- R10: If `fb_above` stays 1, `drv_en` becomes 1 in the same clock that `ref_out` reaches `target`.
- R11: `ss_done` is 1 exactly while the ramp is complete (`ref_out`=`target`) and the block is neither disabled, in no-load handling nor in overvoltage fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-clock strobe, one per switching cycle |
| en | input | 1 | Chip enable; low returns the block to idle |
| vid | input | 6 | Voltage-identification code |
| vid_mode | input | 2 | 0: 6-bit table, 1 or 2: 5-bit tables |
| target | input | REF_W | Final reference in 12.5 mV steps |
| fb_above | input | 1 | Feedback is above the internal reference |
| ov_latched | input | 1 | Overvoltage fault latch |
| ref_out | output | REF_W | Ramping reference in 12.5 mV steps |
| drv_en | output | 1 | Output driver enable |
| pwm_en | output | 1 | PWM enable |
| ovp_sel | output | 1 | Overvoltage threshold select, 1 = shutdown level |
| ss_done | output | 1 | Soft-start complete |

## Verification
Every output is registered, so a level change on `en`, `ov_latched`, `vid` or `fb_above` shows up one clock later. With a tick on each clock, ramp steps appear 17+16k clocks after enable, and the no-load shutdown appears at the third clock after the code. The bench counts clocks from each stimulus and samples on the falling edge. It checks one clock before each due point that the result has not appeared yet, and checks at the due point that it has. The tick-gating case uses every-other-clock ticks, so every due point moves out to a computed later clock.

// File: rtl/softstart_seq.sv
module softstart_seq #(
  parameter int REF_W      = 8,
  parameter int DLY_TICKS  = 16,
  parameter int STEP_TICKS = 16,
  parameter int NL_TICKS   = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             en,
  input  logic [5:0]       vid,
  input  logic [1:0]       vid_mode,
  input  logic [REF_W-1:0] target,
  input  logic             fb_above,
  input  logic             ov_latched,
  output logic [REF_W-1:0] ref_out,
  output logic             drv_en,
  output logic             pwm_en,
  output logic             ovp_sel,
  output logic             ss_done
);
  localparam int CMAX  = (DLY_TICKS > STEP_TICKS) ?
                         ((DLY_TICKS > NL_TICKS) ? DLY_TICKS : NL_TICKS) :
                         ((STEP_TICKS > NL_TICKS) ? STEP_TICKS : NL_TICKS);
  localparam int CNT_W = $clog2(CMAX + 1);

  typedef enum logic [2:0] {S_IDLE, S_DLY, S_RAMP, S_RUN, S_NLW, S_SHUT, S_OVF} st_t;

  st_t              st;
  logic [CNT_W-1:0] cnt;
  logic [REF_W-1:0] ref_q;
  logic             drv_on;
  logic             noload;
  logic [REF_W:0]   ref_nx;

  assign noload  = (vid_mode == 2'd0) ? (vid[5:1] == 5'h1F) : (vid[4:0] == 5'h1F);
  assign ref_nx  = {1'b0, ref_q} + 1'b1;
  assign ref_out = ref_q;
  assign pwm_en  = (st == S_DLY) || (st == S_RAMP) || (st == S_RUN) || (st == S_NLW);
  assign drv_en  = drv_on && pwm_en;
  assign ovp_sel = (st == S_SHUT);
  assign ss_done = (st == S_RUN) && (ref_q == target);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      cnt    <= '0;
      ref_q  <= '0;
      drv_on <= 1'b0;
    end else if (!en) begin
      st     <= S_IDLE;
      cnt    <= '0;
      ref_q  <= '0;
      drv_on <= 1'b0;
    end else if (ov_latched || st == S_OVF) begin
      st     <= S_OVF;
      cnt    <= '0;
      ref_q  <= '0;
      drv_on <= 1'b0;
    end else begin
      case (st)
        S_IDLE: begin
          cnt    <= '0;
          drv_on <= 1'b0;
          st     <= noload ? S_SHUT : S_DLY;
        end
        S_DLY, S_RAMP, S_RUN: begin
          if (noload) begin
            st  <= S_NLW;
            cnt <= '0;
          end else if (st == S_DLY) begin
            if (!fb_above) drv_on <= 1'b1;
            if (tick) begin
              if (cnt == CNT_W'(DLY_TICKS - 1)) begin
                st  <= S_RAMP;
                cnt <= '0;
              end else cnt <= cnt + 1'b1;
            end
          end else if (st == S_RAMP) begin
            if (!fb_above) drv_on <= 1'b1;
            if (ref_q >= target) begin
              st     <= S_RUN;
              ref_q  <= target;
              drv_on <= 1'b1;
            end else if (tick) begin
              if (cnt == CNT_W'(STEP_TICKS - 1)) begin
                cnt   <= '0;
                ref_q <= ref_nx[REF_W-1:0];
                if (ref_nx >= {1'b0, target}) begin
                  st     <= S_RUN;
                  drv_on <= 1'b1;
                end
              end else cnt <= cnt + 1'b1;
            end
          end else begin
            ref_q  <= target;
            drv_on <= 1'b1;
          end
        end
        S_NLW: begin
          if (!noload) begin
            st     <= S_DLY;
            cnt    <= '0;
            ref_q  <= '0;
            drv_on <= 1'b0;
          end else if (tick) begin
            if (cnt == CNT_W'(NL_TICKS - 1)) begin
              st     <= S_SHUT;
              cnt    <= '0;
              ref_q  <= '0;
              drv_on <= 1'b0;
            end else cnt <= cnt + 1'b1;
          end
        end
        S_SHUT: begin
          if (!noload) begin
            st  <= S_DLY;
            cnt <= '0;
          end
        end
        default: st <= S_OVF;
      endcase
    end
  end

  assert_idle_on_disable_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (ref_out == '0 && !drv_en && !pwm_en && !ovp_sel && !ss_done));

  assert_ramp_unit_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_RAMP) |=> (st != S_RAMP || ref_out == $past(ref_out) || ref_out == $past(ref_out) + 1'b1));

  assert_ramp_holds_without_tick_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_RAMP && !tick && en && !ov_latched && !noload && ref_q < target) |=> $stable(ref_out));

  assert_shutdown_on_tick_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(ovp_sel) && $past(st) == S_NLW) |-> $past(tick));

  assert_ov_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_OVF && en) |=> (st == S_OVF && !pwm_en && !ovp_sel));
endmodule

// File: tb/softstart_seq_tb.sv
`timescale 1ns/1ps
module softstart_seq_tb;
  localparam int REF_W = 8;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             tick = 1'b0;
  logic             en = 1'b0;
  logic [5:0]       vid = 6'h20;
  logic [1:0]       vid_mode = 2'd0;
  logic [REF_W-1:0] target = 8'd3;
  logic             fb_above = 1'b0;
  logic             ov_latched = 1'b0;
  logic [REF_W-1:0] ref_out;
  logic             drv_en, pwm_en, ovp_sel, ss_done;

  int checks = 0;
  int errors = 0;
  int tick_per = 1;
  int tph = 0;
  bit done = 0;

  always #4 clk = ~clk;

  softstart_seq #(.REF_W(REF_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .en(en), .vid(vid), .vid_mode(vid_mode),
    .target(target), .fb_above(fb_above), .ov_latched(ov_latched),
    .ref_out(ref_out), .drv_en(drv_en), .pwm_en(pwm_en), .ovp_sel(ovp_sel), .ss_done(ss_done)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic adv(input int n);
    for (int i = 0; i < n; i++) begin
      tick = (tph == 0);
      tph = (tph + 1) % tick_per;
      @(negedge clk);
    end
  endtask

  task automatic restart(input int tgt, input bit fb);
    en = 1'b0; ov_latched = 1'b0; vid = 6'h20; vid_mode = 2'd0;
    target = tgt[REF_W-1:0]; fb_above = fb; tick_per = 1; tph = 0;
    adv(1);
    en = 1'b1; tph = 0;
  endtask

  task automatic t_reset;
    chk("R1 reset ref", ref_out, 0);
    chk("R1 reset pwm", pwm_en, 0);
    chk("R1 reset ovp", ovp_sel, 0);
    chk("R1 reset drv", drv_en, 0);
  endtask

  task automatic t_ramp;
    restart(3, 1'b0);
    adv(1);
    chk("R2 pwm on after enable", pwm_en, 1);
    adv(1);
    chk("R9 drv on with fb low", drv_en, 1);
    adv(30);
    chk("R2 ref still zero at 32", ref_out, 0);
    adv(1);
    chk("R3 first step at 33", ref_out, 1);
    adv(15);
    chk("R3 no step at 48", ref_out, 1);
    adv(1);
    chk("R3 second step at 49", ref_out, 2);
    adv(15);
    chk("R11 not done at 64", ss_done, 0);
    adv(1);
    chk("R3 reach target at 65", ref_out, 3);
    chk("R11 done at target", ss_done, 1);
    adv(40);
    chk("R3 saturate at target", ref_out, 3);
    chk("R11 done holds", ss_done, 1);
  endtask

  task automatic t_precharge;
    restart(6, 1'b1);
    adv(40);
    chk("R9 drv held while fb above", drv_en, 0);
    chk("R9 ref ramping", ref_out, 1);
    fb_above = 1'b0;
    adv(1);
    chk("R9 drv after ref passes fb", drv_en, 1);
  endtask

  task automatic t_above_target;
    restart(2, 1'b1);
    adv(48);
    chk("R10 drv off before end", drv_en, 0);
    adv(1);
    chk("R10 ref at target", ref_out, 2);
    chk("R10 drv forced at end", drv_en, 1);
  endtask

  task automatic t_noload6;
    restart(3, 1'b0);
    adv(70);
    vid = 6'h3F;
    adv(1);
    chk("R6 done cleared", ss_done, 0);
    adv(1);
    chk("R6 pwm kept during wait", pwm_en, 1);
    chk("R6 ovp normal during wait", ovp_sel, 0);
    adv(1);
    chk("R6 pwm off after wait", pwm_en, 0);
    chk("R6 ovp shutdown level", ovp_sel, 1);
    vid = 6'h3E;
    adv(5);
    chk("R5 111110 keeps shutdown", ovp_sel, 1);
    vid = 6'h21;
    adv(1);
    chk("R7 ovp normal on restart", ovp_sel, 0);
    chk("R7 pwm on restart", pwm_en, 1);
    adv(31);
    chk("R7 full delay repeated", ref_out, 0);
    adv(1);
    chk("R7 first step at 33", ref_out, 1);
  endtask

  task automatic t_noload5;
    restart(3, 1'b0);
    adv(70);
    vid = 6'b011111;
    adv(3);
    chk("R5 mode0 011111 is not no-load", pwm_en, 1);
    chk("R5 mode0 done kept", ss_done, 1);
    vid_mode = 2'd2; vid = 6'b111110;
    adv(3);
    chk("R5 mode2 x11110 not no-load", ss_done, 1);
    vid_mode = 2'd1; vid = 6'b011111;
    adv(3);
    chk("R5 mode1 11111 no-load", ovp_sel, 1);
    chk("R5 mode1 pwm off", pwm_en, 0);
  endtask

  task automatic t_ov;
    restart(3, 1'b0);
    adv(70);
    ov_latched = 1'b1;
    adv(1);
    chk("R8 pwm off on ov", pwm_en, 0);
    chk("R8 drv off on ov", drv_en, 0);
    chk("R8 done off on ov", ss_done, 0);
    ov_latched = 1'b0; vid = 6'h3F;
    adv(5);
    chk("R8 no-load does not change ov state", ovp_sel, 0);
    vid = 6'h21;
    adv(40);
    chk("R8 valid code does not clear ov", pwm_en, 0);
    chk("R8 ref held zero", ref_out, 0);
    en = 1'b0;
    adv(1);
    en = 1'b1;
    adv(1);
    chk("R8 cleared by disable", pwm_en, 1);
  endtask

  task automatic t_disable;
    restart(5, 1'b0);
    adv(50);
    en = 1'b0;
    adv(1);
    chk("R1 ref zero on disable", ref_out, 0);
    chk("R1 pwm off on disable", pwm_en, 0);
    chk("R1 drv off on disable", drv_en, 0);
  endtask

  task automatic t_tickgate;
    restart(3, 1'b0);
    tick_per = 2;
    adv(64);
    chk("R4 no step at 64", ref_out, 0);
    adv(1);
    chk("R4 step at 65", ref_out, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    adv(2);
    t_reset;
    t_ramp;
    t_precharge;
    t_above_target;
    t_noload6;
    t_noload5;
    t_ov;
    t_disable;
    t_tickgate;
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(200000 * 8);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=1 expected=0");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule